// File: doc/BRIEF.md
# Serial Clock Divider with Duty Correction

This block derives the serial flash clock from a faster system clock. A five-bit divider code selects the division ratio through a non-linear map. Codes 0 to 15 give divisors 2 to 17 in steps of one. Codes 16 to 31 give even divisors 18 to 48 in steps of two.

An odd divisor normally leaves the high phase one system clock longer than the low phase. An optional correction fixes this by delaying the rising edge by half a system clock. That half-clock delay comes from a falling-edge register. Two stretch bits add one system clock to the low phase (setup margin) or to the high phase (hold margin).

The shifter receives one-clock-wide rise and fall strobes. It also receives a rise qualifier that is registered on the falling edge, so it lags the rise strobe by half a clock. While the run input is low, the clock rests at the idle level of the chosen SPI mode. During the same idle time the block captures its configuration: divider code, correction enable and stretch bits.

Top module: `sck_divider`

## Requirements
- R1: For divider codes 0 to 15, the serial clock period is code+2 system clocks (no stretch, no correction).
- R2: For divider codes 16 to 31, the period is 2*code-14 system clocks, so code 16 gives 18 and code 31 gives 48.
- R3: Divider code, correction enable and both stretch bits are captured on each clock edge while run is low and held while run is high. Changes made during a run have no effect on the output. After reset the captured code is 8 (divisor 10).
- R4: With an even divisor N, the high and low phases each last N/2 system clocks.
- R5: With an odd divisor N and correction off, the high phase is (N+1)/2 and the low phase is (N-1)/2 system clocks.
- R6: With correction on and an odd divisor, the rising edge is delayed by half a system clock, so both phases last N half-clocks. With an even divisor, correction changes nothing.
- R7: The setup-stretch bit adds one system clock to every low phase while running.
- R8: The hold-stretch bit adds one system clock to every high phase while running.
- R9: While run is low, the clock sits at the mode bit sampled on the previous edge: 0 gives a low idle level (mode 0), 1 gives a high idle level (mode 3).
- R10: rise_stb is high for the one system clock that begins at the edge where the uncorrected clock goes high. fall_stb does the same for the falling edge. Neither is ever high while run is low.
- R11: rise_dly is high for one system clock, starting at the falling system-clock edge that follows the start of a rise strobe, and it is low while run is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables clock generation; configuration is captured while low |
| spi_mode3 | input | 1 | Idle level select: 0 low (mode 0), 1 high (mode 3) |
| div_code | input | 5 | Divider code |
| duty_fix | input | 1 | Half-clock rise delay for odd divisors |
| stretch_lo | input | 1 | Adds one clock to the low phase |
| stretch_hi | input | 1 | Adds one clock to the high phase |
| sck | output | 1 | Divided serial clock |
| rise_stb | output | 1 | One-clock strobe at a rising phase change |
| fall_stb | output | 1 | One-clock strobe at a falling phase change |
| rise_dly | output | 1 | Rise strobe delayed by half a system clock |

## Verification
The critical overlap is an odd divisor with correction on, combined with a setup stretch. The half-clock rise delay and the extra low-phase clock then land on the same low phase, and the two together must give a low width of 2*((N-1)/2+1)+1 half-clocks. Random mixes of code, correction and both stretch bits provoke this case repeatedly, and directed cases cover the divisor extremes. The bench samples sck in every half clock, measures the completed high and low widths, and compares them to widths it computes from the requirements. At each falling-edge sample it also compares rise_dly with the observed rising transition.

// File: rtl/sck_divider.sv
module sck_divider #(
  parameter int CODE_W = 5,
  parameter int CNT_W  = 7,
  parameter logic [CODE_W-1:0] RST_CODE = CODE_W'(8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              spi_mode3,
  input  logic [CODE_W-1:0] div_code,
  input  logic              duty_fix,
  input  logic              stretch_lo,
  input  logic              stretch_hi,
  output logic              sck,
  output logic              rise_stb,
  output logic              fall_stb,
  output logic              rise_dly
);
  localparam int HALF_CODE = 1 << (CODE_W - 1);

  logic [CODE_W-1:0] code_q;
  logic              fix_q, slo_q, shi_q;
  logic [CNT_W-1:0]  divisor, code_w, lo_len, hi_len, cur_len, cnt;
  logic              odd, ph, ph_n, rise_q, fall_q, rise_n, use_fix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RST_CODE;
      fix_q  <= 1'b0;
      slo_q  <= 1'b0;
      shi_q  <= 1'b0;
    end else if (!run) begin
      code_q <= div_code;
      fix_q  <= duty_fix;
      slo_q  <= stretch_lo;
      shi_q  <= stretch_hi;
    end
  end

  assign code_w  = CNT_W'(code_q);
  assign divisor = code_q[CODE_W-1] ? ((code_w << 1) - CNT_W'(HALF_CODE - 2))
                                    : (code_w + CNT_W'(2));
  assign odd     = divisor[0];
  assign lo_len  = (divisor >> 1) + CNT_W'(slo_q);
  assign hi_len  = (divisor >> 1) + CNT_W'(odd) + CNT_W'(shi_q);
  assign cur_len = ph ? hi_len : lo_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= 1'b0;
      cnt    <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (!run) begin
      ph     <= spi_mode3;
      cnt    <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (cnt == cur_len - CNT_W'(1)) begin
      ph     <= ~ph;
      cnt    <= '0;
      rise_q <= ~ph;
      fall_q <= ph;
    end else begin
      cnt    <= cnt + CNT_W'(1);
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_n   <= 1'b0;
      rise_n <= 1'b0;
    end else begin
      ph_n   <= ph;
      rise_n <= rise_q & run;
    end
  end

  assign use_fix  = run & fix_q & odd;
  assign sck      = use_fix ? (ph & ph_n) : ph;
  assign rise_stb = rise_q & run;
  assign fall_stb = fall_q & run;
  assign rise_dly = rise_n & run;

  assert_no_idle_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!rise_stb && !fall_stb && !rise_dly));

  assert_rise_marks_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (ph && !$past(ph)));

  assert_fall_marks_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (!ph && $past(ph)));

  assert_cfg_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(code_q) && $stable(fix_q) && $stable(slo_q) && $stable(shi_q)));

  assert_phase_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < cur_len));

  assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run)) |-> (sck == $past(spi_mode3)));
endmodule

// File: tb/tb_sck_divider.sv
`timescale 1ns/1ps
module tb_sck_divider;
  localparam int NC = 160;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, spi_mode3 = 1'b0;
  logic [4:0] div_code = 5'd0;
  logic duty_fix = 1'b0, stretch_lo = 1'b0, stretch_hi = 1'b0;
  logic sck, rise_stb, fall_stb, rise_dly;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sck_divider dut (
    .clk(clk), .rst_n(rst_n), .run(run), .spi_mode3(spi_mode3),
    .div_code(div_code), .duty_fix(duty_fix), .stretch_lo(stretch_lo),
    .stretch_hi(stretch_hi), .sck(sck), .rise_stb(rise_stb),
    .fall_stb(fall_stb), .rise_dly(rise_dly));

  function automatic int exp_div(input int code);
    return (code < 16) ? code + 2 : 2 * code - 14;
  endfunction

  function automatic int exp_hi(input int n, input bit fix, input bit shi);
    return 2 * (n / 2 + n % 2 + shi) - ((fix && (n % 2 == 1)) ? 1 : 0);
  endfunction

  function automatic int exp_lo(input int n, input bit fix, input bit slo);
    return 2 * (n / 2 + slo) + ((fix && (n % 2 == 1)) ? 1 : 0);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  bit hs [0:2*NC-1];
  bit rs [0:NC-1];
  bit fs [0:NC-1];
  bit rd [0:NC-1];

  task automatic run_case(input int code, input bit fix, input bit slo, input bit shi,
                          input bit mode, input bit mid_change, input bit keep_cfg,
                          input int exp_n, input string req);
    int hi_w, lo_w, bad_r, bad_f, bad_d, runlen, nrun;
    bit cur;
    if (!keep_cfg) begin
      @(negedge clk); #2;
      run = 1'b0; div_code = 5'(code); duty_fix = fix;
      stretch_lo = slo; stretch_hi = shi; spi_mode3 = mode;
      repeat (3) @(negedge clk);
      #2;
    end
    for (int k = 0; k < NC; k++) begin
      @(posedge clk); #2;
      hs[2*k] = sck; rs[k] = rise_stb; fs[k] = fall_stb;
      @(negedge clk); #2;
      hs[2*k+1] = sck; rd[k] = rise_dly;
      if (k == 1) run = 1'b1;
      if (k == 20 && mid_change) begin
        div_code = ~div_code; duty_fix = ~duty_fix;
        stretch_lo = ~stretch_lo; stretch_hi = ~stretch_hi;
      end
    end
    run = 1'b0;
    bad_r = 0; bad_f = 0; bad_d = 0;
    for (int k = 3; k < NC; k++) begin
      if (fs[k] != (!hs[2*k] && hs[2*k-2])) bad_f++;
      if (!(fix && exp_n % 2 == 1) && rs[k] != (hs[2*k] && !hs[2*k-2])) bad_r++;
      if (rd[k] != (hs[2*k+1] && !hs[2*k-1])) bad_d++;
    end
    check("R10 fall strobe mismatches", bad_f, 0);
    check("R10 rise strobe mismatches", bad_r, 0);
    check("R11 delayed rise mismatches", bad_d, 0);
    hi_w = -1; lo_w = -1; nrun = 0;
    cur = hs[4]; runlen = 0;
    for (int i = 4; i < 2*NC; i++) begin
      if (hs[i] == cur) runlen++;
      else begin
        if (nrun > 0) begin
          if (cur && hi_w < 0) hi_w = runlen;
          if (!cur && lo_w < 0) lo_w = runlen;
        end
        nrun++; cur = hs[i]; runlen = 1;
      end
    end
    check({req, " high half-clocks"}, hi_w, exp_hi(exp_n, fix, shi));
    check({req, " low half-clocks"},  lo_w, exp_lo(exp_n, fix, slo));
  endtask

  initial begin
    #(8 * 200000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unsigned junk;
    junk = $urandom(32'h5EED_0042);
    // Reset state; R3 reset code: run held high through reset, input code ignored
    run = 1'b1; div_code = 5'd3;
    repeat (3) @(negedge clk);
    check("R9 reset sck", int'(sck), 0);
    check("R10 reset strobes", int'(rise_stb | fall_stb | rise_dly), 0);
    rst_n = 1'b1;
    run_case(3, 0, 0, 0, 0, 0, 1, 10, "R3 reset code");
    // Idle levels, R9
    @(negedge clk); #2; run = 1'b0; spi_mode3 = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 mode3 idle high", int'(sck), 1);
    check("R10 idle no strobe", int'(rise_stb | fall_stb | rise_dly), 0);
    spi_mode3 = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 mode0 idle low", int'(sck), 0);
    // Directed corners
    run_case(0,  0, 0, 0, 0, 0, 0, 2,  "R1 R4 code0");
    run_case(15, 0, 0, 0, 1, 0, 0, 17, "R1 R5 code15");
    run_case(16, 0, 0, 0, 0, 0, 0, 18, "R2 R4 code16");
    run_case(31, 0, 0, 0, 1, 0, 0, 48, "R2 R4 code31");
    run_case(1,  1, 0, 0, 0, 0, 0, 3,  "R6 odd corrected");
    run_case(16, 1, 0, 0, 0, 0, 0, 18, "R6 even correction no effect");
    run_case(4,  0, 1, 0, 0, 0, 0, 6,  "R7 setup stretch");
    run_case(4,  0, 0, 1, 1, 0, 0, 6,  "R8 hold stretch");
    run_case(7,  1, 1, 1, 0, 0, 0, 9,  "R6 R7 R8 combined");
    run_case(5,  0, 0, 0, 0, 1, 0, 7,  "R3 mid-run change ignored");
    for (int t = 0; t < 24; t++) begin
      int c;
      bit f, sl, sh, m;
      c = int'($urandom_range(31, 0));
      f = 1'($urandom); sl = 1'($urandom); sh = 1'($urandom); m = 1'($urandom);
      run_case(c, f, sl, sh, m, 0, 0, exp_div(c), "R1 R2 R5 R6 R7 R8 random");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule